// File: doc/BRIEF.md
# Video Input Timing Analyzer

This block observes a parallel video input and works out the geometry of the incoming stream. It samples data enable, horizontal sync, vertical sync and a link-lock flag once per pixel, marked by a one-cycle pixel strobe in the system clock domain. It reports the active width and height, both sync pulse widths, the horizontal porches in pixels and the vertical porches in lines. It also reports the polarity of each sync and whether a stream is present.

Sync polarity is found by measuring both phases of each sync signal. The shorter phase is taken as the pulse. Once the polarity is known, each sync is turned into an "asserted" signal, and the porch and size counters run against that signal.

All numeric results are copied into a status set in one step, at the assertion of vertical sync that closes a frame containing active pixels. That copy happens only while a stream is present. Otherwise the status keeps its last values, so a host can read a consistent set at any time.

Top module: `vid_timing_analyzer`

## Requirements
- R1: `stream_ok` is 1 only when all three of these hold: `link_lock` is 1, the pixel strobe is running, and `de` has changed level within the last `SYNC_TIMEOUT` pixel strobes. With the link locked but `de` frozen, `stream_ok` is 0.
- R2: The pixel strobe counts as running until `PCLK_TIMEOUT` (default 1024) consecutive system clocks pass with `pix_ce` low. After that, `stream_ok` is 0.
- R3: `hs_pol` and `vs_pol` use the code 0 for active low and 1 for active high. The active level is the level whose most recent complete phase is shorter. A tie gives 0.
- R4: A sync with no level change within `SYNC_TIMEOUT` pixel strobes reports polarity code 2. It stays at 2 until both of its phases have been measured again.
- R5: `hs_width` and `vs_width` give the length of the asserted phase of each sync, counted in pixel strobes.
- R6: `h_back` is the number of pixel strobes strictly between the last asserted horizontal sync sample and the first `de`=1 sample of the line.
- R7: `h_front` is the number of pixel strobes strictly between the last `de`=1 sample of a line and the next horizontal sync assertion.
- R8: `v_back` is the number of lines without `de` between the last vertical sync line and the first line with `de`. `v_front` is the number of lines without `de` between the last line with `de` and the vertical sync assertion. Line boundaries are horizontal sync assertions.
- R9: `act_width` is the length of a run of `de`=1 samples within a line. `act_height` is the number of lines in a frame that contain `de`=1.
- R10: All numeric outputs change together, one cycle after the vertical sync assertion that closes a frame with active lines. They hold their values while `stream_ok` is 0.
- R11: After reset, every numeric output is 0, both polarity codes are 2 and `stream_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | One-cycle strobe per pixel |
| link_lock | input | 1 | Link lock flag from the receiver |
| de | input | 1 | Data enable, active high |
| hsync | input | 1 | Raw horizontal sync, either polarity |
| vsync | input | 1 | Raw vertical sync, either polarity |
| stream_ok | output | 1 | Stream detected |
| hs_pol | output | 2 | Horizontal sync polarity code |
| vs_pol | output | 2 | Vertical sync polarity code |
| act_width | output | 16 | Active pixels per line |
| act_height | output | 16 | Active lines per frame |
| hs_width | output | 24 | Horizontal sync pulse width in pixels |
| vs_width | output | 24 | Vertical sync pulse width in pixels |
| h_back | output | 16 | Horizontal back porch in pixels |
| h_front | output | 16 | Horizontal front porch in pixels |
| v_back | output | 16 | Vertical back porch in lines |
| v_front | output | 16 | Vertical front porch in lines |

## Verification
Two formats with different sizes and opposite sync polarities are sent one after the other. This shows that every field is measured rather than remembered, and that the porch counters follow the detected polarity rather than a fixed one.

A phase with frozen syncs and a moving `de` separates the "no sync" code from a loss of stream. A frozen `de` with the link still locked shows that lock alone is not enough to report a stream.

Dropping the link while a different format is being sent, and stopping the pixel strobe, both show that the status set is held. The strobe test also places the clock-activity timeout on the correct side of its limit.

// File: rtl/vta_pkg.sv
package vta_pkg;
    localparam int CNT_W   = 16;
    localparam int PULSE_W = 24;

    typedef enum logic [1:0] {
        POL_LOW  = 2'd0,
        POL_HIGH = 2'd1,
        POL_NONE = 2'd2
    } pol_e;

    typedef struct packed {
        logic [CNT_W-1:0] act_w;
        logic [CNT_W-1:0] hbp;
        logic [CNT_W-1:0] hfp;
    } hmeas_t;

    typedef struct packed {
        logic [CNT_W-1:0] act_h;
        logic [CNT_W-1:0] vbp;
        logic [CNT_W-1:0] vfp;
    } vmeas_t;

    typedef struct packed {
        hmeas_t             h;
        vmeas_t             v;
        logic [PULSE_W-1:0] hsw;
        logic [PULSE_W-1:0] vsw;
    } fmt_t;

    function automatic pol_e pick_pol(input logic [PULSE_W-1:0] hi_len,
                                      input logic [PULSE_W-1:0] lo_len);
        return (hi_len < lo_len) ? POL_HIGH : POL_LOW;
    endfunction

    function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/vta_sync_meter.sv
module vta_sync_meter
    import vta_pkg::*;
#(
    parameter int TIMEOUT = 4000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               sig,
    output pol_e               pol,
    output logic [PULSE_W-1:0] width,
    output logic               act,
    output logic               assert_ev
);
    localparam int IW = $clog2(TIMEOUT + 1);
    localparam logic [IW-1:0] LIM = IW'(TIMEOUT);

    logic               prev, seen_edge, got_hi, got_lo;
    logic [PULSE_W-1:0] run, hi_len, lo_len;
    logic [IW-1:0]      idle;
    logic               edge_now;

    assign edge_now = tick && (sig != prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= 1'b0;
            seen_edge <= 1'b0;
            got_hi    <= 1'b0;
            got_lo    <= 1'b0;
            run       <= '0;
            hi_len    <= '0;
            lo_len    <= '0;
            idle      <= '0;
        end else if (tick) begin
            prev <= sig;
            if (sig != prev) begin
                run       <= 1;
                idle      <= '0;
                seen_edge <= 1'b1;
                if (seen_edge) begin
                    if (prev) begin
                        hi_len <= run;
                        got_hi <= 1'b1;
                    end else begin
                        lo_len <= run;
                        got_lo <= 1'b1;
                    end
                end
            end else begin
                if (run != '1) run <= run + 1'b1;
                if (idle == LIM) begin
                    got_hi    <= 1'b0;
                    got_lo    <= 1'b0;
                    seen_edge <= 1'b0;
                end else begin
                    idle <= idle + 1'b1;
                end
            end
        end
    end

    assign pol = (got_hi && got_lo && idle != LIM) ? pick_pol(hi_len, lo_len) : POL_NONE;

    always_comb begin
        act       = 1'b0;
        assert_ev = 1'b0;
        width     = '0;
        if (pol == POL_HIGH) begin
            act       = sig;
            assert_ev = tick && sig && !prev;
            width     = hi_len;
        end else if (pol == POL_LOW) begin
            act       = !sig;
            assert_ev = tick && !sig && prev;
            width     = lo_len;
        end
    end

    // R3
    pol_width_chk: assert property (@(posedge clk) disable iff (rst)
        (pol != POL_NONE) |-> (width != '0));

    // R4
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !edge_now && idle == LIM) |=> (!got_hi && !got_lo));
endmodule

// File: rtl/vta_horiz.sv
module vta_horiz
    import vta_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   de,
    input  logic   hs_act,
    input  logic   hs_ev,
    output hmeas_t meas
);
    logic [CNT_W-1:0] since_sync, since_de, run;
    logic             armed, de_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_sync <= '0;
            since_de   <= '0;
            run        <= '0;
            armed      <= 1'b0;
            de_line    <= 1'b0;
            meas       <= '0;
        end else if (tick) begin
            since_sync <= hs_act ? '0 : inc_sat(since_sync);
            since_de   <= de ? '0 : inc_sat(since_de);
            run        <= de ? inc_sat(run) : '0;

            if (hs_act)      armed <= 1'b1;
            else if (de)     armed <= 1'b0;
            if (de && armed && !hs_act) meas.hbp <= since_sync;

            if (!de && run != '0) meas.act_w <= run;

            if (hs_ev)       de_line <= 1'b0;
            else if (de)     de_line <= 1'b1;
            if (hs_ev && de_line) meas.hfp <= since_de;
        end
    end

    // R6
    hbp_once_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && de && armed && !hs_act) |=> !armed);
endmodule

// File: rtl/vta_vert.sv
module vta_vert
    import vta_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   de,
    input  logic   vs_act,
    input  logic   hs_ev,
    input  logic   vs_ev,
    output vmeas_t meas,
    output logic   frame_done
);
    logic             de_line, vs_line, armed, had_de;
    logic [CNT_W-1:0] blank_cnt, tail_cnt, line_cnt, vbp_q;
    logic [CNT_W-1:0] tail_eff, lines_eff;
    logic             had_de_eff;

    always_comb begin
        tail_eff   = tail_cnt;
        lines_eff  = line_cnt;
        had_de_eff = had_de;
        if (hs_ev) begin
            if (de_line) begin
                tail_eff   = '0;
                lines_eff  = inc_sat(line_cnt);
                had_de_eff = 1'b1;
            end else if (!vs_line) begin
                tail_eff = inc_sat(tail_cnt);
            end
        end
        meas.act_h = lines_eff;
        meas.vbp   = vbp_q;
        meas.vfp   = tail_eff;
        frame_done = vs_ev && had_de_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_line   <= 1'b0;
            vs_line   <= 1'b0;
            armed     <= 1'b0;
            had_de    <= 1'b0;
            blank_cnt <= '0;
            tail_cnt  <= '0;
            line_cnt  <= '0;
            vbp_q     <= '0;
        end else if (tick) begin
            if (hs_ev) begin
                de_line  <= de;
                vs_line  <= vs_act;
                tail_cnt <= tail_eff;
                line_cnt <= lines_eff;
                had_de   <= had_de_eff;
                if (vs_line) begin
                    blank_cnt <= '0;
                    armed     <= 1'b1;
                end else if (armed && !de_line) begin
                    blank_cnt <= inc_sat(blank_cnt);
                end else if (armed && de_line) begin
                    vbp_q <= blank_cnt;
                    armed <= 1'b0;
                end
            end else begin
                if (de)     de_line <= 1'b1;
                if (vs_act) vs_line <= 1'b1;
            end
            if (vs_ev) begin
                line_cnt <= '0;
                had_de   <= 1'b0;
            end
        end
    end

    // R8
    vbp_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && hs_ev && vs_line) |=> armed);
endmodule

// File: rtl/vid_timing_analyzer.sv
module vid_timing_analyzer
    import vta_pkg::*;
#(
    parameter int SYNC_TIMEOUT = 4000000,
    parameter int PCLK_TIMEOUT = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_ce,
    input  logic               link_lock,
    input  logic               de,
    input  logic               hsync,
    input  logic               vsync,
    output logic               stream_ok,
    output logic [1:0]         hs_pol,
    output logic [1:0]         vs_pol,
    output logic [CNT_W-1:0]   act_width,
    output logic [CNT_W-1:0]   act_height,
    output logic [PULSE_W-1:0] hs_width,
    output logic [PULSE_W-1:0] vs_width,
    output logic [CNT_W-1:0]   h_back,
    output logic [CNT_W-1:0]   h_front,
    output logic [CNT_W-1:0]   v_back,
    output logic [CNT_W-1:0]   v_front
);
    localparam int WW = $clog2(PCLK_TIMEOUT + 1);
    localparam logic [WW-1:0] WLIM = WW'(PCLK_TIMEOUT);
    localparam int DW = $clog2(SYNC_TIMEOUT + 1);
    localparam logic [DW-1:0] DLIM = DW'(SYNC_TIMEOUT);

    pol_e               hp, vp;
    logic [PULSE_W-1:0] hsw, vsw;
    logic               hs_act, hs_ev, vs_act, vs_ev, frame_done;
    hmeas_t             hm;
    vmeas_t             vm;
    fmt_t               stat;

    // pixel strobe activity, system clock domain
    logic [WW-1:0] quiet;
    logic          clk_alive;
    always_ff @(posedge clk) begin
        if (rst)                 quiet <= WLIM;
        else if (pix_ce)         quiet <= '0;
        else if (quiet != WLIM)  quiet <= quiet + 1'b1;
    end
    assign clk_alive = (quiet != WLIM);

    // data enable movement
    logic          de_prev, de_seen;
    logic [DW-1:0] de_idle;
    always_ff @(posedge clk) begin
        if (rst) begin
            de_prev <= 1'b0;
            de_seen <= 1'b0;
            de_idle <= '0;
        end else if (pix_ce) begin
            de_prev <= de;
            if (de != de_prev) begin
                de_idle <= '0;
                de_seen <= 1'b1;
            end else if (de_idle != DLIM) begin
                de_idle <= de_idle + 1'b1;
            end else begin
                de_seen <= 1'b0;
            end
        end
    end

    assign stream_ok = link_lock && clk_alive && de_seen && (de_idle != DLIM);

    vta_sync_meter #(.TIMEOUT(SYNC_TIMEOUT)) u_hs (
        .clk(clk), .rst(rst), .tick(pix_ce), .sig(hsync),
        .pol(hp), .width(hsw), .act(hs_act), .assert_ev(hs_ev)
    );

    vta_sync_meter #(.TIMEOUT(SYNC_TIMEOUT)) u_vs (
        .clk(clk), .rst(rst), .tick(pix_ce), .sig(vsync),
        .pol(vp), .width(vsw), .act(vs_act), .assert_ev(vs_ev)
    );

    vta_horiz u_h (
        .clk(clk), .rst(rst), .tick(pix_ce), .de(de),
        .hs_act(hs_act), .hs_ev(hs_ev), .meas(hm)
    );

    vta_vert u_v (
        .clk(clk), .rst(rst), .tick(pix_ce), .de(de), .vs_act(vs_act),
        .hs_ev(hs_ev), .vs_ev(vs_ev), .meas(vm), .frame_done(frame_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (frame_done && stream_ok) begin
            stat.h   <= hm;
            stat.v   <= vm;
            stat.hsw <= hsw;
            stat.vsw <= vsw;
        end
    end

    assign hs_pol     = hp;
    assign vs_pol     = vp;
    assign act_width  = stat.h.act_w;
    assign h_back     = stat.h.hbp;
    assign h_front    = stat.h.hfp;
    assign act_height = stat.v.act_h;
    assign v_back     = stat.v.vbp;
    assign v_front    = stat.v.vfp;
    assign hs_width   = stat.hsw;
    assign vs_width   = stat.vsw;

    // R2
    strobe_alive_chk: assert property (@(posedge clk) disable iff (rst)
        pix_ce |=> clk_alive);

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stream_ok |=> $stable(stat));
endmodule

// File: tb/tb_vid_timing_analyzer.sv
module tb_vid_timing_analyzer;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_ce = 1'b0, link_lock = 1'b0, de = 1'b0, hsync = 1'b0, vsync = 1'b0;
    logic        stream_ok;
    logic [1:0]  hs_pol, vs_pol;
    logic [15:0] act_width, act_height, h_back, h_front, v_back, v_front;
    logic [23:0] hs_width, vs_width;

    int checks = 0;
    int errors = 0;
    int e_w, e_h, e_hsw, e_vsw, e_hbp, e_hfp, e_vbp, e_vfp, e_hpol, e_vpol, e_str;
    bit cmp_num = 0, cmp_pol = 0, cmp_str = 0;
    string pol_req = "R3";
    string str_req = "R1";

    vid_timing_analyzer #(.SYNC_TIMEOUT(TMO), .PCLK_TIMEOUT(1024)) dut (
        .clk(clk), .rst(rst), .pix_ce(pix_ce), .link_lock(link_lock), .de(de),
        .hsync(hsync), .vsync(vsync), .stream_ok(stream_ok), .hs_pol(hs_pol),
        .vs_pol(vs_pol), .act_width(act_width), .act_height(act_height),
        .hs_width(hs_width), .vs_width(vs_width), .h_back(h_back), .h_front(h_front),
        .v_back(v_back), .v_front(v_front)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (cmp_num) begin
                chk("R9", "act_width", act_width, e_w);
                chk("R9", "act_height", act_height, e_h);
                chk("R5", "hs_width", hs_width, e_hsw);
                chk("R5", "vs_width", vs_width, e_vsw);
                chk("R6", "h_back", h_back, e_hbp);
                chk("R7", "h_front", h_front, e_hfp);
                chk("R8", "v_back", v_back, e_vbp);
                chk("R8", "v_front", v_front, e_vfp);
            end
            if (cmp_pol) begin
                chk(pol_req, "hs_pol", hs_pol, e_hpol);
                chk(pol_req, "vs_pol", vs_pol, e_vpol);
            end
            if (cmp_str) chk(str_req, "stream_ok", stream_ok, e_str);
        end
    end

    task automatic send_frame(input int aw, input int hfp, input int hsw, input int hbp,
                              input int ah, input int vfp, input int vsw, input int vbp,
                              input bit hpos, input bit vpos);
        int ht;
        int vt;
        ht = hsw + hbp + aw + hfp;
        vt = vsw + vbp + ah + vfp;
        for (int l = 0; l < vt; l++) begin
            for (int p = 0; p < ht; p++) begin
                bit hsa;
                bit vsa;
                bit dea;
                hsa = (p < hsw);
                vsa = (l < vsw);
                dea = (l >= vsw + vbp) && (l < vsw + vbp + ah) &&
                      (p >= hsw + hbp) && (p < hsw + hbp + aw);
                @(negedge clk);
                pix_ce = 1'b1;
                hsync  = hpos ? hsa : !hsa;
                vsync  = vpos ? vsa : !vsa;
                de     = dea;
            end
        end
    endtask

    // format A: active-high syncs; format B: active-low syncs
    task automatic send_a(input int n);
        for (int i = 0; i < n; i++) send_frame(16, 3, 2, 4, 6, 2, 2, 3, 1'b1, 1'b1);
    endtask
    task automatic send_b(input int n);
        for (int i = 0; i < n; i++) send_frame(20, 5, 3, 2, 5, 3, 1, 2, 1'b0, 1'b0);
    endtask

    task automatic expect_a();
        e_w = 16; e_h = 6; e_hsw = 2; e_vsw = 2 * 25;
        e_hbp = 4; e_hfp = 3; e_vbp = 3; e_vfp = 2; e_hpol = 1; e_vpol = 1;
    endtask
    task automatic expect_b();
        e_w = 20; e_h = 5; e_hsw = 3; e_vsw = 1 * 30;
        e_hbp = 2; e_hfp = 5; e_vbp = 2; e_vfp = 3; e_hpol = 0; e_vpol = 0;
    endtask

    task automatic ticks(input int n, input bit de_toggle);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_ce = 1'b1;
            de = de_toggle ? ((i % 30) >= 5 && (i % 30) < 25) : 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "act_width", act_width, 0);
        chk("R11", "act_height", act_height, 0);
        chk("R11", "hs_width", hs_width, 0);
        chk("R11", "v_front", v_front, 0);
        chk("R11", "hs_pol", hs_pol, 2);
        chk("R11", "vs_pol", vs_pol, 2);
        chk("R11", "stream_ok", stream_ok, 0);

        // R1: locked link with frozen DE is not a stream
        link_lock = 1'b1;
        ticks(20, 1'b0);
        chk("R1", "stream_ok locked, de idle", stream_ok, 0);

        // format A, active high
        send_a(5);
        expect_a(); e_str = 1; pol_req = "R3"; str_req = "R1";
        cmp_num = 1; cmp_pol = 1; cmp_str = 1;
        send_a(3);
        cmp_num = 0; cmp_pol = 0; cmp_str = 0;

        // format B, active low, different geometry
        send_b(5);
        expect_b();
        cmp_num = 1; cmp_pol = 1; cmp_str = 1;
        send_b(3);
        cmp_pol = 0;

        // R4: syncs frozen at inactive level, DE moving
        hsync = 1'b1; vsync = 1'b1;
        ticks(1200, 1'b1);
        e_hpol = 2; e_vpol = 2; pol_req = "R4";
        cmp_pol = 1;
        ticks(300, 1'b1);

        // R1: DE stops, link still locked
        cmp_str = 0;
        ticks(TMO + 20, 1'b0);
        e_str = 0; str_req = "R1";
        cmp_str = 1;
        ticks(50, 1'b0);
        cmp_str = 0; cmp_pol = 0; cmp_num = 0;

        // R10: link drop freezes status while another format arrives
        send_a(6);
        expect_a(); pol_req = "R3";
        cmp_num = 1;
        send_a(1);
        @(negedge clk);
        link_lock = 1'b0;
        @(negedge clk);
        e_str = 0; str_req = "R1";
        cmp_str = 1;
        send_b(3);
        cmp_str = 0; cmp_num = 0;

        // R2: pixel strobe watchdog
        link_lock = 1'b1;
        send_a(6);
        expect_a(); e_str = 1; str_req = "R2";
        cmp_num = 1; cmp_pol = 1; cmp_str = 1;
        send_a(1);
        cmp_str = 0;
        @(negedge clk);
        pix_ce = 1'b0;
        repeat (1000) @(negedge clk);
        chk("R2", "stream_ok before strobe timeout", stream_ok, 1);
        repeat (40) @(negedge clk);
        chk("R2", "stream_ok after strobe timeout", stream_ok, 0);
        cmp_num = 0; cmp_pol = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule